// File: doc/BRIEF.md
# Egress Traffic-Class Scheduler

This block decides which of eight egress traffic classes on one port may send its next frame. Each class reports whether its queue holds data. A flow-control mask arrives per switch priority, and a programmable table folds that mask onto the classes, so pausing one priority stops every class that priority is mapped to. A class may run as strict priority or as deficit-weighted round robin. It may also be held back by its own token-bucket rate limiter.

The block drives a one-hot grant to the chosen class. The grant stays until the transmitter reports completion with the frame length. That length is charged to the class's round-robin deficit and to its token bucket. A small register file written through a simple write port holds the table and the per-class settings. After reset every priority points at class 0, every class is strict, and every limiter is off.

Top module: `egress_tc_sched`

## Requirements
- R1: After reset the grant is zero, every priority maps to class 0, every class is strict and every rate limiter is off, so pausing any priority blocks class 0.
- R2: Configuration writes take effect on the next cycle. Address 0 holds the priority table, with bits [3p+2:3p] giving the class of priority p. Address 1 bit c set selects round robin for class c, and clear selects strict. Address 8+c bits [6:0] hold the weight of class c. Address 16+c holds the limiter of class c, with enable in bit 31 and rate in bits [15:0]. Writes to any other address change nothing.
- R3: A class is paused while any priority mapped to it has its pause bit set, and a paused class never receives a new grant.
- R4: A class whose queue-not-empty flag is low never receives a new grant.
- R5: An eligible strict class always wins over round-robin classes, and among strict classes the highest class number wins.
- R6: Round-robin classes keep signed deficits. When no eligible round-robin class has a positive deficit, every eligible one gains weight×16 bytes, with a weight of 0 counted as 1. The search for a positive deficit starts after the last round-robin class granted. A completion subtracts the length from the deficit. A class with an empty queue has its deficit cleared.
- R7: An enabled limiter adds its rate each cycle, caps at 2048, and subtracts the length on completion. The class is ineligible while the count is negative. A disabled limiter never blocks its class.
- R8: The grant is one-hot or zero and holds until the completion pulse. It clears on the edge that samples the pulse. A new grant appears on the edge after an idle cycle in which a class is eligible. A completion pulse while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| q_nonempty_i | input | 8 | Per-class queue holds data |
| pause_prio_i | input | 8 | Per-priority flow-control pause |
| tx_done_i | input | 1 | Granted frame finished |
| tx_len_i | input | 14 | Length of the finished frame in bytes |
| grant_o | output | 8 | One-hot grant to a class |

## Verification
Two strict classes requesting at once, and a low strict class against higher round-robin classes, separate a correct priority order from an inverted one or a lost strict preference. A pair of round-robin classes weighted two to one with equal frames must produce the exact sequence 0,1,0,1,0,0, which exposes a wrong refill amount, search origin or charge. A pause on a remapped priority, first at the reset table and then after a rewrite, shows whether the table really steers the mask. A long frame on a rate-limited class must open a gap of about one hundred cycles, and the same frame with the limiter off must open none. A held grant with its queue withdrawn, and a write to an unused address, show that neither disturbs the state.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned TC_NUM   = 8;
  localparam int unsigned PRIO_NUM = 8;
  localparam int unsigned CFG_AW   = 5;
  localparam int unsigned CFG_DW   = 32;
  localparam int unsigned WT_W     = 7;
  localparam int unsigned RATE_W   = 16;
  localparam int unsigned SHP_EN_BIT = 31;

  localparam logic [CFG_AW-1:0] ADDR_MAP      = 5'd0;
  localparam logic [CFG_AW-1:0] ADDR_ALGO     = 5'd1;
  localparam logic [CFG_AW-1:0] ADDR_WT_BASE  = 5'd8;
  localparam logic [CFG_AW-1:0] ADDR_SHP_BASE = 5'd16;
endpackage

// File: rtl/tcs_cfg_regs.sv
module tcs_cfg_regs #(
  parameter int unsigned NUM_TC   = tcs_pkg::TC_NUM,
  parameter int unsigned NUM_PRIO = tcs_pkg::PRIO_NUM,
  parameter int unsigned TC_W     = $clog2(NUM_TC)
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    we_i,
  input  logic [tcs_pkg::CFG_AW-1:0]              addr_i,
  input  logic [tcs_pkg::CFG_DW-1:0]              wdata_i,
  output logic [NUM_PRIO*TC_W-1:0]                prio_map_o,
  output logic [NUM_TC-1:0]                       algo_rr_o,
  output logic [NUM_TC*tcs_pkg::WT_W-1:0]         weight_o,
  output logic [NUM_TC-1:0]                       shp_en_o,
  output logic [NUM_TC*tcs_pkg::RATE_W-1:0]       shp_rate_o
);
  import tcs_pkg::*;
  localparam int unsigned MAP_W = NUM_PRIO * TC_W;

  logic [MAP_W-1:0]         map_q, map_d;
  logic [NUM_TC-1:0]        algo_q, algo_d;
  logic [NUM_TC*WT_W-1:0]   wt_q, wt_d;
  logic [NUM_TC-1:0]        en_q, en_d;
  logic [NUM_TC*RATE_W-1:0] rate_q, rate_d;
  logic                     unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    map_d  = map_q;
    algo_d = algo_q;
    wt_d   = wt_q;
    en_d   = en_q;
    rate_d = rate_q;
    if (addr_i == ADDR_MAP)  map_d  = wdata_i[MAP_W-1:0];
    if (addr_i == ADDR_ALGO) algo_d = wdata_i[NUM_TC-1:0];
    for (int c = 0; c < NUM_TC; c++) begin
      if (addr_i == ADDR_WT_BASE + CFG_AW'(c))
        wt_d[c*WT_W +: WT_W] = wdata_i[WT_W-1:0];
      if (addr_i == ADDR_SHP_BASE + CFG_AW'(c)) begin
        en_d[c]                  = wdata_i[SHP_EN_BIT];
        rate_d[c*RATE_W +: RATE_W] = wdata_i[RATE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      algo_q <= '0;
      wt_q   <= '0;
      en_q   <= '0;
      rate_q <= '0;
    end else if (we_i) begin
      map_q  <= map_d;
      algo_q <= algo_d;
      wt_q   <= wt_d;
      en_q   <= en_d;
      rate_q <= rate_d;
    end
  end

  assign prio_map_o = map_q;
  assign algo_rr_o  = algo_q;
  assign weight_o   = wt_q;
  assign shp_en_o   = en_q;
  assign shp_rate_o = rate_q;

  // R2
  cfg_map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_MAP) |=> (prio_map_o == $past(wdata_i[MAP_W-1:0])));
  // R2
  cfg_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(prio_map_o) && $stable(algo_rr_o) && $stable(shp_en_o)));
endmodule

// File: rtl/tcs_pause_map.sv
module tcs_pause_map #(
  parameter int unsigned NUM_TC   = tcs_pkg::TC_NUM,
  parameter int unsigned NUM_PRIO = tcs_pkg::PRIO_NUM,
  parameter int unsigned TC_W     = $clog2(NUM_TC)
) (
  input  logic [NUM_PRIO*TC_W-1:0] prio_map_i,
  input  logic [NUM_PRIO-1:0]      pause_prio_i,
  output logic [NUM_TC-1:0]        tc_paused_o
);
  for (genvar c = 0; c < NUM_TC; c++) begin : g_tc
    always_comb begin
      tc_paused_o[c] = 1'b0;
      for (int p = 0; p < NUM_PRIO; p++) begin
        if (pause_prio_i[p] && (prio_map_i[p*TC_W +: TC_W] == TC_W'(c)))
          tc_paused_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcs_shaper.sv
module tcs_shaper #(
  parameter int unsigned LEN_W      = 14,
  parameter int unsigned RATE_W     = tcs_pkg::RATE_W,
  parameter int          BUCKET_MAX = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              charge_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              ok_o
);
  localparam int unsigned TOK_W = LEN_W + 2;
  localparam int unsigned SUM_W = ((RATE_W > TOK_W) ? RATE_W : TOK_W) + 2;

  logic signed [TOK_W-1:0] tok_q, tok_d;
  logic signed [SUM_W-1:0] sum, cap_s, len_s;

  always_comb begin
    cap_s = SUM_W'(BUCKET_MAX);
    len_s = charge_i ? $signed(SUM_W'(len_i)) : '0;
    sum   = SUM_W'(tok_q) + $signed(SUM_W'(rate_i));
    if (sum > cap_s) sum = cap_s;
    if (!en_i) tok_d = TOK_W'(cap_s);
    else       tok_d = TOK_W'(sum - len_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= TOK_W'(BUCKET_MAX);
    else        tok_q <= tok_d;
  end

  assign ok_o = !tok_q[TOK_W-1];

  // R7
  tok_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_q <= TOK_W'(BUCKET_MAX)));
  // R7
  shp_off_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ok_o);
endmodule

// File: rtl/tcs_wrr.sv
module tcs_wrr #(
  parameter int unsigned NUM_TC  = tcs_pkg::TC_NUM,
  parameter int unsigned TC_W    = $clog2(NUM_TC),
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned QUANTUM = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_TC-1:0]               rr_mask_i,
  input  logic [NUM_TC-1:0]               elig_i,
  input  logic [NUM_TC-1:0]               qne_i,
  input  logic [NUM_TC*tcs_pkg::WT_W-1:0] weight_i,
  input  logic                            sel_en_i,
  input  logic                            take_i,
  input  logic                            charge_i,
  input  logic [TC_W-1:0]                 charge_tc_i,
  input  logic [LEN_W-1:0]                charge_len_i,
  output logic                            pick_vld_o,
  output logic [TC_W-1:0]                 pick_tc_o
);
  import tcs_pkg::*;
  localparam int unsigned DEF_W = LEN_W + 3;
  localparam int          MAX_Q = ((1 << WT_W) - 1) * QUANTUM;

  logic signed [DEF_W-1:0] def_q [NUM_TC];
  logic signed [DEF_W-1:0] def_d [NUM_TC];
  logic [TC_W-1:0]         last_q, last_d;
  logic [NUM_TC-1:0]       cand, pos;
  logic                    refill;

  always_comb begin
    cand = elig_i & rr_mask_i;
    for (int c = 0; c < NUM_TC; c++) pos[c] = cand[c] && (def_q[c] > 0);
    refill = sel_en_i && (|cand) && !(|pos);
    pick_vld_o = 1'b0;
    pick_tc_o  = '0;
    for (int k = NUM_TC; k >= 1; k--) begin
      if (pos[(int'(last_q) + k) % NUM_TC]) begin
        pick_vld_o = 1'b1;
        pick_tc_o  = TC_W'((int'(last_q) + k) % NUM_TC);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_TC; c++) begin
      def_d[c] = def_q[c];
      if (!rr_mask_i[c] || !qne_i[c]) begin
        def_d[c] = '0;
      end else begin
        if (refill && cand[c]) begin
          if (weight_i[c*WT_W +: WT_W] == '0)
            def_d[c] = def_d[c] + DEF_W'(QUANTUM);
          else
            def_d[c] = def_d[c] + DEF_W'(int'(weight_i[c*WT_W +: WT_W]) * QUANTUM);
        end
        if (charge_i && (charge_tc_i == TC_W'(c)))
          def_d[c] = def_d[c] - $signed(DEF_W'(charge_len_i));
      end
    end
    last_d = (take_i && pick_vld_o) ? pick_tc_o : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_TC; c++) def_q[c] <= '0;
      last_q <= TC_W'(NUM_TC - 1);
    end else begin
      for (int c = 0; c < NUM_TC; c++) def_q[c] <= def_d[c];
      last_q <= last_d;
    end
  end

  for (genvar c = 0; c < NUM_TC; c++) begin : g_chk
    // R6
    deficit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (def_q[c] <= DEF_W'(MAX_Q)));
  end
endmodule

// File: rtl/egress_tc_sched.sv
module egress_tc_sched #(
  parameter int unsigned NUM_TC     = tcs_pkg::TC_NUM,
  parameter int unsigned NUM_PRIO   = tcs_pkg::PRIO_NUM,
  parameter int unsigned LEN_W      = 14,
  parameter int          BUCKET_MAX = 2048,
  parameter int unsigned QUANTUM    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we_i,
  input  logic [tcs_pkg::CFG_AW-1:0] cfg_addr_i,
  input  logic [tcs_pkg::CFG_DW-1:0] cfg_wdata_i,
  input  logic [NUM_TC-1:0]          q_nonempty_i,
  input  logic [NUM_PRIO-1:0]        pause_prio_i,
  input  logic                       tx_done_i,
  input  logic [LEN_W-1:0]           tx_len_i,
  output logic [NUM_TC-1:0]          grant_o
);
  import tcs_pkg::*;
  localparam int unsigned TC_W = $clog2(NUM_TC);

  logic [NUM_PRIO*TC_W-1:0]   prio_map;
  logic [NUM_TC-1:0]          rr_mask, shp_en, shp_ok, tc_paused, elig, s_cand;
  logic [NUM_TC*WT_W-1:0]     weight;
  logic [NUM_TC*RATE_W-1:0]   shp_rate;
  logic [NUM_TC-1:0]          grant_q, grant_d, shp_charge;
  logic                       s_vld, w_vld, idle, charge;
  logic [TC_W-1:0]            s_tc, w_tc, grant_tc;

  tcs_cfg_regs #(.NUM_TC(NUM_TC), .NUM_PRIO(NUM_PRIO), .TC_W(TC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .prio_map_o(prio_map), .algo_rr_o(rr_mask),
    .weight_o(weight), .shp_en_o(shp_en), .shp_rate_o(shp_rate));

  tcs_pause_map #(.NUM_TC(NUM_TC), .NUM_PRIO(NUM_PRIO), .TC_W(TC_W)) u_pause (
    .prio_map_i(prio_map), .pause_prio_i(pause_prio_i), .tc_paused_o(tc_paused));

  for (genvar c = 0; c < NUM_TC; c++) begin : g_shp
    assign shp_charge[c] = tx_done_i & grant_q[c];
    tcs_shaper #(.LEN_W(LEN_W), .RATE_W(RATE_W), .BUCKET_MAX(BUCKET_MAX)) u_shp (
      .clk(clk), .rst_n(rst_n), .en_i(shp_en[c]),
      .rate_i(shp_rate[c*RATE_W +: RATE_W]), .charge_i(shp_charge[c]),
      .len_i(tx_len_i), .ok_o(shp_ok[c]));
  end

  assign elig   = q_nonempty_i & ~tc_paused & shp_ok;
  assign s_cand = elig & ~rr_mask;
  assign idle   = (grant_q == '0);
  assign charge = tx_done_i && !idle;

  always_comb begin
    s_vld = |s_cand;
    s_tc  = '0;
    for (int c = 0; c < NUM_TC; c++) if (s_cand[c]) s_tc = TC_W'(c);
    grant_tc = '0;
    for (int c = 0; c < NUM_TC; c++) if (grant_q[c]) grant_tc = TC_W'(c);
  end

  tcs_wrr #(.NUM_TC(NUM_TC), .TC_W(TC_W), .LEN_W(LEN_W), .QUANTUM(QUANTUM)) u_wrr (
    .clk(clk), .rst_n(rst_n), .rr_mask_i(rr_mask), .elig_i(elig),
    .qne_i(q_nonempty_i), .weight_i(weight), .sel_en_i(idle && !s_vld),
    .take_i(idle && !s_vld), .charge_i(charge), .charge_tc_i(grant_tc),
    .charge_len_i(tx_len_i), .pick_vld_o(w_vld), .pick_tc_o(w_tc));

  always_comb begin
    grant_d = grant_q;
    if (!idle) begin
      if (tx_done_i) grant_d = '0;
    end else if (s_vld) begin
      grant_d = NUM_TC'(1) << s_tc;
    end else if (w_vld) begin
      grant_d = NUM_TC'(1) << w_tc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grant_q <= '0;
    else        grant_q <= grant_d;
  end

  assign grant_o = grant_q;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !tx_done_i) |=> (grant_q == $past(grant_q)));
  // R8
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && tx_done_i) |=> (grant_q == '0));
  // R3
  grant_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ((grant_q & $past(tc_paused)) == '0));
  // R4
  grant_qne_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ((grant_q & ~$past(q_nonempty_i)) == '0));
  // R5
  strict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (|s_cand)) |=> ((grant_q & $past(rr_mask)) == '0));
  // R7
  grant_shaper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ((grant_q & ~$past(shp_ok)) == '0));
endmodule

// File: tb/test_egress_tc_sched.sv
`timescale 1ns/1ps
module test_egress_tc_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  q_ne = '0;
  logic [7:0]  pause = '0;
  logic        tx_done = 1'b0;
  logic [13:0] tx_len = '0;
  logic [7:0]  grant;

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;
  int exp_q[$];
  string tag_q[$];
  logic [7:0] prev_g = '0;
  int e_tc;
  string e_tag;
  int w;

  always #10 clk = ~clk;

  egress_tc_sched i_egress_tc_sched (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .q_nonempty_i(q_ne), .pause_prio_i(pause),
    .tx_done_i(tx_done), .tx_len_i(tx_len), .grant_o(grant));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each fresh grant with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!$onehot0(grant)) chk(1'b0, "R8 onehot", grant, 0);
      if (grant != 8'd0 && prev_g == 8'd0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected grant", grant, 0);
        end else begin
          e_tc  = exp_q.pop_front();
          e_tag = tag_q.pop_front();
          chk(grant == (8'd1 << e_tc), e_tag, grant, 1 << e_tc);
        end
      end
    end
    prev_g = grant;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic serve(input int tc, input int len, input string tag, output int waited);
    exp_q.push_back(tc);
    tag_q.push_back(tag);
    waited = 0;
    while (grant == 8'd0 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    if (grant == 8'd0) begin
      chk(1'b0, {tag, " timeout"}, 0, 1 << tc);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end else begin
      tx_done = 1'b1; tx_len = 14'(len);
      @(negedge clk);
      tx_done = 1'b0;
    end
  endtask

  task automatic idle_for(input int n, input string tag);
    repeat (n) @(negedge clk);
    chk(grant == 8'd0, tag, grant, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grant == 8'd0, "R1 reset grant", grant, 0);

    // R1 R3: default table sends priority 7 to class 0
    pause = 8'h80; q_ne = 8'h01;
    idle_for(20, "R1 R3 default map pause");
    pause = 8'h00;
    serve(0, 64, "R1 class0 after unpause", w);
    q_ne = 8'h00;
    @(negedge clk);

    // R5 R8: strict order and prompt regrant
    q_ne = 8'h05;
    serve(2, 64, "R5 highest strict", w);
    serve(2, 64, "R5 highest strict again", w);
    chk(w <= 2, "R8 regrant delay", w, 1);
    q_ne = 8'h01;
    serve(0, 64, "R5 lone strict", w);
    q_ne = 8'h00;
    @(negedge clk);

    // R2 R3: remap priority 7 to class 5
    wr(5'd0, 32'd5 << 21);
    pause = 8'h80; q_ne = 8'h21;
    serve(0, 64, "R2 R3 remapped pause skips class5", w);
    pause = 8'h81;
    idle_for(20, "R3 both classes paused");
    pause = 8'h00;
    serve(5, 64, "R3 class5 after unpause", w);
    q_ne = 8'h00;
    wr(5'd0, 32'd0);

    // R2: unused address changes nothing
    wr(5'd2, 32'hFFFF_FFFF);
    q_ne = 8'h03;
    serve(1, 64, "R2 ignored write keeps strict", w);
    q_ne = 8'h00;
    @(negedge clk);

    // R6: weights 2:1, equal frames
    wr(5'd1, 32'h03);
    wr(5'd8, 32'd2);
    wr(5'd9, 32'd1);
    q_ne = 8'h03;
    serve(0, 16, "R6 rr step1", w);
    serve(1, 16, "R6 rr step2", w);
    serve(0, 16, "R6 rr step3", w);
    serve(1, 16, "R6 rr step4", w);
    serve(0, 16, "R6 rr step5", w);
    serve(0, 16, "R6 rr step6", w);
    q_ne = 8'h00;
    @(negedge clk);

    // R5: strict class 0 beats round-robin classes 1 and 2
    wr(5'd1, 32'h06);
    q_ne = 8'h07;
    serve(0, 16, "R5 strict over rr", w);
    q_ne = 8'h00;
    wr(5'd1, 32'h00);

    // R7: limiter on class 3 at rate 1
    wr(5'd19, 32'h8000_0001);
    q_ne = 8'h08;
    serve(3, 2148, "R7 limited first", w);
    serve(3, 16, "R7 limited second", w);
    chk(w >= 90 && w <= 110, "R7 refill gap", w, 100);
    wr(5'd19, 32'h0000_0001);
    serve(3, 2148, "R7 disabled first", w);
    serve(3, 16, "R7 disabled second", w);
    chk(w <= 3, "R7 no gap when off", w, 1);
    q_ne = 8'h00;
    @(negedge clk);

    // R8: grant held without completion, idle completion ignored
    tx_done = 1'b1; tx_len = 14'd16;
    @(negedge clk);
    tx_done = 1'b0;
    chk(grant == 8'd0, "R8 idle done ignored", grant, 0);
    exp_q.push_back(1); tag_q.push_back("R8 hold grant");
    q_ne = 8'h02;
    repeat (3) @(negedge clk);
    q_ne = 8'h00;
    repeat (10) @(negedge clk);
    chk(grant == 8'h02, "R8 grant held", grant, 2);
    tx_done = 1'b1; tx_len = 14'd16;
    @(negedge clk);
    tx_done = 1'b0;
    chk(grant == 8'h00, "R8 release", grant, 0);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

    repeat (3) @(negedge clk);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule